// File: doc/BRIEF.md
# Configurable Two-Stage Multiply-Add Slice

This slice multiplies four pairs of signed 18-bit operands. It merges the products in two adder stages and delivers one registered result for each valid input beat. A two-bit mode input chooses how the first-stage and second-stage adders are reused:

- as the final step of a signed 36×36 multiply with a full 72-bit product;
- as a plain sum of four products;
- as a running accumulator;
- as a sum that also adds a chain value from a neighbouring slice.

The three 44-bit modes wrap their sums to 44 bits. A build-time parameter places or removes a register between the first and second adder stages. A valid flag moves through that register with the data. After the second stage, an optional round-half-up at a selectable bit position and an optional signed clamp to a selectable width act before the output register. The raw 44-bit second-stage value is also registered onto a chain output, so slices can be cascaded.

Top module: `madd_slice`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `res_valid`, `ovf`, `result` and `chain_out` are all zero.
- R2: With `mode`=0, A is the signed 36-bit value {a lane1, a lane0}: lane1 is the signed high half and lane0 the unsigned low half. B is formed the same way from the b lanes. `result` is the full signed 72-bit product A·B.
- R3: With `mode`=1, `result` is the 44-bit wrapped sum of a_i·b_i for lanes 0..3, each operand signed, sign-extended to 72 bits.
- R4: With `mode`=2, the 44-bit wrapped sum is the four-product sum plus the 44-bit second-stage value of the previous valid beat. When `acc_clr` is 1 on that beat, the previous value is replaced by zero.
- R5: With `mode`=3, the 44-bit wrapped sum is the four-product sum plus the signed `chain_in` presented on the same beat.
- R6: `chain_out` holds the unrounded 44-bit second-stage value of the latest valid beat. In `mode`=0 this is the low 44 bits of the product. It appears in the same cycle as `result`.
- R7: `res_valid` pulses once for each `in_valid` beat. It comes USE_PIPE+1 cycles later, so 2 cycles with the pipeline register and 1 without.
- R8: When `rnd_en`=1 and `rnd_pos`=k>0, the value becomes floor((x + 2^(k-1)) / 2^k)·2^k. When k=0 or `rnd_en`=0 the value is unchanged.
- R9: When `sat_en`=1, the rounded value is clamped to the signed range of w=`sat_w` bits, with w below 2 treated as 2 and w above 72 treated as 72. `ovf` is 1 exactly on a valid beat that was clamped, and 0 on every other beat.
- R10: A cycle without `in_valid` changes neither `result` nor `chain_out`, does not advance the accumulator, and yields `ovf`=0.
- R11: In `mode`=0, lanes 2 and 3 of `a_in` and `b_in` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls on this cycle form a beat |
| mode | input | 2 | 0 wide multiply, 1 sum of four, 2 accumulate, 3 chained sum |
| acc_clr | input | 1 | Start a new accumulation on this beat |
| a_in | input | 4*IN_W | Four signed A lanes, lane i at bits [i*IN_W +: IN_W] |
| b_in | input | 4*IN_W | Four signed B lanes, same layout |
| chain_in | input | ACC_W | Signed value from a neighbouring slice |
| rnd_en | input | 1 | Enable rounding |
| rnd_pos | input | 7 | Rounding bit position k |
| sat_en | input | 1 | Enable saturation |
| sat_w | input | 7 | Saturation width in bits |
| res_valid | output | 1 | Result valid pulse |
| result | output | 4*IN_W | Registered signed result |
| ovf | output | 1 | Clamp occurred on this result |
| chain_out | output | ACC_W | Registered raw 44-bit second-stage value |

## Verification
With the pipeline register present, a beat driven at one falling edge passes two rising edges and is visible at the second falling edge after it. Without that register it is visible at the first. The bench drives a pipelined and an unpipelined instance from the same stream. It keeps a two-entry queue of predicted outputs and compares the older entry against the pipelined instance and the newer entry against the other, so each prediction is sampled in exactly the cycle its latency dictates. Idle beats push a "hold" prediction, so results must stay unchanged between beats.

// File: rtl/madd_pkg.sv
package madd_pkg;
  localparam int POS_W = 7;

  typedef enum logic [1:0] {
    MD_MUL36 = 2'd0,
    MD_SUM4  = 2'd1,
    MD_ACC   = 2'd2,
    MD_CHAIN = 2'd3
  } madd_mode_e;

  typedef struct packed {
    madd_mode_e       mode;
    logic             clr;
    logic             rnd_en;
    logic [POS_W-1:0] rnd_pos;
    logic             sat_en;
    logic [POS_W-1:0] sat_w;
  } madd_ctl_t;
endpackage

// File: rtl/madd_mul_fs.sv
// Four signed multipliers plus the two first-stage adders.
module madd_mul_fs #(
  parameter int IN_W = 18,
  parameter int FSW  = 57
) (
  input  logic [4*IN_W-1:0]     a_in,
  input  logic [4*IN_W-1:0]     b_in,
  input  logic                  is36,
  output logic signed [FSW-1:0] fs0,
  output logic signed [FSW-1:0] fs1
);
  localparam int NM = 4;
  localparam int OW = IN_W + 1;
  localparam int PW = 2 * OW;

  logic signed [PW-1:0]  prod [NM];
  logic signed [FSW-1:0] pe   [NM];

  for (genvar i = 0; i < NM; i++) begin : g_lane
    // wide mode: lane i multiplies A half (i%2) by B half (i/2)
    localparam int XI = i % 2;
    localparam int YI = i / 2;
    localparam bit XS = (XI == 1);
    localparam bit YS = (YI == 1);
    logic [IN_W-1:0]     xs, ys;
    logic                xsg, ysg;
    logic signed [OW-1:0] xo, yo;

    assign xs  = is36 ? a_in[XI*IN_W +: IN_W] : a_in[i*IN_W +: IN_W];
    assign ys  = is36 ? b_in[YI*IN_W +: IN_W] : b_in[i*IN_W +: IN_W];
    assign xsg = is36 ? XS : 1'b1;
    assign ysg = is36 ? YS : 1'b1;
    assign xo  = {xsg & xs[IN_W-1], xs};
    assign yo  = {ysg & ys[IN_W-1], ys};
    assign prod[i] = xo * yo;
    assign pe[i]   = {{(FSW-PW){prod[i][PW-1]}}, prod[i]};
  end

  always_comb begin
    if (is36) begin
      fs0 = pe[0] + (pe[1] <<< IN_W);
      fs1 = pe[2] + (pe[3] <<< IN_W);
    end else begin
      fs0 = pe[0] + pe[1];
      fs1 = pe[2] + pe[3];
    end
  end
endmodule

// File: rtl/madd_sum2.sv
// Second-stage adder with accumulator feedback and chain input.
module madd_sum2
  import madd_pkg::*;
#(
  parameter int IN_W  = 18,
  parameter int ACC_W = 44,
  parameter int FSW   = 57,
  parameter int RW    = 72
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  v,
  input  madd_mode_e            mode,
  input  logic                  clr,
  input  logic signed [FSW-1:0] fs0,
  input  logic signed [FSW-1:0] fs1,
  input  logic [ACC_W-1:0]      chain_in,
  output logic signed [RW-1:0]  x,
  output logic [ACC_W-1:0]      acc_q
);
  logic signed [RW-1:0] fs0e, fs1e, fbe, full36, sum;
  logic [ACC_W-1:0]     fb, s44, nxt;

  assign fs0e = {{(RW-FSW){fs0[FSW-1]}}, fs0};
  assign fs1e = {{(RW-FSW){fs1[FSW-1]}}, fs1};

  always_comb begin
    unique case (mode)
      MD_ACC:   fb = clr ? '0 : acc_q;
      MD_CHAIN: fb = chain_in;
      default:  fb = '0;
    endcase
  end

  assign fbe    = {{(RW-ACC_W){fb[ACC_W-1]}}, fb};
  assign full36 = fs0e + (fs1e <<< (2*IN_W - IN_W));
  assign sum    = fs0e + fs1e + fbe;
  assign s44    = sum[ACC_W-1:0];
  assign nxt    = (mode == MD_MUL36) ? full36[ACC_W-1:0] : s44;
  assign x      = (mode == MD_MUL36) ? full36
                                     : {{(RW-ACC_W){s44[ACC_W-1]}}, s44};

  always_ff @(posedge clk) begin
    if (rst)    acc_q <= '0;
    else if (v) acc_q <= nxt;
  end

  // R10
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !v |=> $stable(acc_q));
endmodule

// File: rtl/madd_rndsat.sv
// Round-half-up at bit k, then signed clamp to a chosen width.
module madd_rndsat
  import madd_pkg::*;
#(
  parameter int RW = 72
) (
  input  logic signed [RW-1:0] x,
  input  logic                 rnd_en,
  input  logic [POS_W-1:0]     rnd_pos,
  input  logic                 sat_en,
  input  logic [POS_W-1:0]     sat_w,
  output logic [RW-1:0]        y,
  output logic                 ovf
);
  localparam int EW = RW + 1;
  localparam logic [EW-1:0]    ONE  = EW'(1);
  localparam logic [POS_W-1:0] RW_P = POS_W'(RW);
  localparam logic [POS_W-1:0] P1   = POS_W'(1);
  localparam logic [POS_W-1:0] P2   = POS_W'(2);

  logic signed [EW-1:0] xe, half, mask, r, hi, lo, c;
  logic                 rnd_on;
  logic [POS_W-1:0]     w_eff;

  assign xe     = {x[RW-1], x};
  assign rnd_on = rnd_en && (rnd_pos != '0);
  assign half   = rnd_on ? $signed(ONE << (rnd_pos - P1)) : '0;
  assign mask   = rnd_on ? $signed(~((ONE << rnd_pos) - ONE)) : '1;
  assign r      = (xe + half) & mask;

  always_comb begin
    if (sat_w < P2)        w_eff = P2;
    else if (sat_w > RW_P) w_eff = RW_P;
    else                   w_eff = sat_w;
  end

  assign hi = $signed((ONE << (w_eff - P1)) - ONE);
  assign lo = ~hi;

  always_comb begin
    ovf = 1'b0;
    c   = r;
    if (sat_en && (r > hi)) begin
      c   = hi;
      ovf = 1'b1;
    end else if (sat_en && (r < lo)) begin
      c   = lo;
      ovf = 1'b1;
    end
    if (sat_en) begin
      // R9
      sat_range_chk: assert ((c <= hi) && (c >= lo));
    end
  end

  assign y = c[RW-1:0];
endmodule

// File: rtl/madd_slice.sv
module madd_slice
  import madd_pkg::*;
#(
  parameter int IN_W     = 18,
  parameter int ACC_W    = 44,
  parameter bit USE_PIPE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [1:0]           mode,
  input  logic                 acc_clr,
  input  logic [4*IN_W-1:0]    a_in,
  input  logic [4*IN_W-1:0]    b_in,
  input  logic [ACC_W-1:0]     chain_in,
  input  logic                 rnd_en,
  input  logic [POS_W-1:0]     rnd_pos,
  input  logic                 sat_en,
  input  logic [POS_W-1:0]     sat_w,
  output logic                 res_valid,
  output logic [4*IN_W-1:0]    result,
  output logic                 ovf,
  output logic [ACC_W-1:0]     chain_out
);
  localparam int RW    = 4 * IN_W;
  localparam int FSW   = 2 * (IN_W + 1) + IN_W + 1;
  localparam int CTL_W = $bits(madd_ctl_t);
  localparam int PD_W  = 2 * FSW + ACC_W + CTL_W;

  madd_ctl_t            s1_ctl, s2_ctl;
  logic signed [FSW-1:0] s1_fs0, s1_fs1, s2_fs0, s2_fs1;
  logic [ACC_W-1:0]     s2_chain;
  logic [PD_W-1:0]      s1_pd, s2_pd;
  logic                 s2_v;
  logic signed [RW-1:0] s2_x;
  logic [RW-1:0]        rs_y;
  logic                 rs_ovf;

  assign s1_ctl = '{mode: madd_mode_e'(mode), clr: acc_clr, rnd_en: rnd_en,
                    rnd_pos: rnd_pos, sat_en: sat_en, sat_w: sat_w};

  madd_mul_fs #(.IN_W(IN_W), .FSW(FSW)) u_mul (
    .a_in (a_in),
    .b_in (b_in),
    .is36 (s1_ctl.mode == MD_MUL36),
    .fs0  (s1_fs0),
    .fs1  (s1_fs1)
  );

  assign s1_pd = {s1_fs0, s1_fs1, chain_in, s1_ctl};

  if (USE_PIPE) begin : g_pipe
    logic            pv;
    logic [PD_W-1:0] pd;
    always_ff @(posedge clk) begin
      if (rst) pv <= 1'b0;
      else     pv <= in_valid;
      pd <= s1_pd;
    end
    assign s2_v  = pv;
    assign s2_pd = pd;
  end else begin : g_nopipe
    assign s2_v  = in_valid;
    assign s2_pd = s1_pd;
  end

  assign {s2_fs0, s2_fs1, s2_chain, s2_ctl} = s2_pd;

  madd_sum2 #(.IN_W(IN_W), .ACC_W(ACC_W), .FSW(FSW), .RW(RW)) u_sum (
    .clk      (clk),
    .rst      (rst),
    .v        (s2_v),
    .mode     (s2_ctl.mode),
    .clr      (s2_ctl.clr),
    .fs0      (s2_fs0),
    .fs1      (s2_fs1),
    .chain_in (s2_chain),
    .x        (s2_x),
    .acc_q    (chain_out)
  );

  madd_rndsat #(.RW(RW)) u_rs (
    .x       (s2_x),
    .rnd_en  (s2_ctl.rnd_en),
    .rnd_pos (s2_ctl.rnd_pos),
    .sat_en  (s2_ctl.sat_en),
    .sat_w   (s2_ctl.sat_w),
    .y       (rs_y),
    .ovf     (rs_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      ovf       <= 1'b0;
      result    <= '0;
    end else begin
      res_valid <= s2_v;
      ovf       <= s2_v & rs_ovf;
      if (s2_v) result <= rs_y;
    end
  end

  if (USE_PIPE) begin : g_lat2
    // R7
    lat_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2)) |-> (res_valid == $past(in_valid, 2)));
  end else begin : g_lat1
    // R7
    lat_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (res_valid == $past(in_valid)));
  end

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !s2_v |=> $stable(result));

  // R9
  ovf_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !ovf);
endmodule

// File: tb/madd_slice_tb.sv
module madd_slice_tb;
  localparam int IN_W = 18;
  localparam int ACC_W = 44;
  localparam int RW = 72;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst;
  logic             in_valid, acc_clr, rnd_en, sat_en;
  logic [1:0]       mode;
  logic [RW-1:0]    a_in, b_in;
  logic [ACC_W-1:0] chain_in;
  logic [6:0]       rnd_pos, sat_w;

  logic             p_v, p_ovf, n_v, n_ovf;
  logic [RW-1:0]    p_res, n_res;
  logic [ACC_W-1:0] p_ch, n_ch;

  madd_slice #(.IN_W(IN_W), .ACC_W(ACC_W), .USE_PIPE(1'b1)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .acc_clr(acc_clr),
    .a_in(a_in), .b_in(b_in), .chain_in(chain_in), .rnd_en(rnd_en),
    .rnd_pos(rnd_pos), .sat_en(sat_en), .sat_w(sat_w),
    .res_valid(p_v), .result(p_res), .ovf(p_ovf), .chain_out(p_ch));

  madd_slice #(.IN_W(IN_W), .ACC_W(ACC_W), .USE_PIPE(1'b0)) u_dut_np (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .acc_clr(acc_clr),
    .a_in(a_in), .b_in(b_in), .chain_in(chain_in), .rnd_en(rnd_en),
    .rnd_pos(rnd_pos), .sat_en(sat_en), .sat_w(sat_w),
    .res_valid(n_v), .result(n_res), .ovf(n_ovf), .chain_out(n_ch));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // prediction queue: slot 0 newest, slot 1 one beat older
  logic             e_v   [2];
  logic [RW-1:0]    e_res [2];
  logic             e_ovf [2];
  logic [ACC_W-1:0] e_ch  [2];
  string            e_tag [2];

  logic [ACC_W-1:0] macc;
  logic [RW-1:0]    last_res;

  task automatic chk(input string req, input string what,
                     input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] lanes(input logic [17:0] l0, input logic [17:0] l1,
                                          input logic [17:0] l2, input logic [17:0] l3);
    return {l3, l2, l1, l0};
  endfunction

  task automatic predict(input logic v, input logic [1:0] md, input logic clr,
                         input logic [RW-1:0] a, input logic [RW-1:0] b,
                         input logic [ACC_W-1:0] ch, input logic ren,
                         input logic [6:0] rp, input logic sen, input logic [6:0] sw);
    logic signed [79:0] x, s, ai, bi, fd, hi, lo, A80, B80;
    logic of;
    string tg;
    int w;
    if (!v) begin
      e_v[0] = 1'b0; e_res[0] = last_res; e_ovf[0] = 1'b0; e_ch[0] = macc;
      e_tag[0] = "R10";
      return;
    end
    if (md == 2'd0) begin
      A80 = {{44{a[35]}}, a[35:0]};
      B80 = {{44{b[35]}}, b[35:0]};
      x = A80 * B80;
      macc = x[43:0];
      tg = "R2/R11";
    end else begin
      s = '0;
      for (int i = 0; i < 4; i++) begin
        ai = {{62{a[i*18+17]}}, a[i*18 +: 18]};
        bi = {{62{b[i*18+17]}}, b[i*18 +: 18]};
        s = s + ai * bi;
      end
      if (md == 2'd2)      fd = clr ? 80'sd0 : {{36{macc[43]}}, macc};
      else if (md == 2'd3) fd = {{36{ch[43]}}, ch};
      else                 fd = 80'sd0;
      s = s + fd;
      macc = s[43:0];
      x = {{36{macc[43]}}, macc};
      tg = (md == 2'd1) ? "R3" : (md == 2'd2) ? "R4" : "R5";
    end
    if (ren && rp != 7'd0) begin
      x = (x + (80'sd1 <<< (rp - 7'd1))) & ~((80'sd1 <<< rp) - 80'sd1);
      tg = {tg, "/R8"};
    end
    of = 1'b0;
    if (sen) begin
      w = int'(sw);
      if (w < 2) w = 2;
      if (w > 72) w = 72;
      hi = (80'sd1 <<< (w - 1)) - 80'sd1;
      lo = -hi - 80'sd1;
      if (x > hi) begin x = hi; of = 1'b1; end
      else if (x < lo) begin x = lo; of = 1'b1; end
      tg = {tg, "/R9"};
    end
    last_res = x[71:0];
    e_v[0] = 1'b1; e_res[0] = x[71:0]; e_ovf[0] = of; e_ch[0] = macc; e_tag[0] = tg;
  endtask

  task automatic beat(input logic v, input logic [1:0] md, input logic clr,
                      input logic [RW-1:0] a, input logic [RW-1:0] b,
                      input logic [ACC_W-1:0] ch, input logic ren,
                      input logic [6:0] rp, input logic sen, input logic [6:0] sw);
    @(negedge clk);
    // pipelined instance: beat driven two edges ago (R7)
    chk("R7", "valid pipe", 80'(p_v), 80'(e_v[1]));
    chk(e_tag[1], "result pipe", 80'(p_res), 80'(e_res[1]));
    chk("R9", "ovf pipe", 80'(p_ovf), 80'(e_ovf[1]));
    chk("R6", "chain pipe", 80'(p_ch), 80'(e_ch[1]));
    // unpipelined instance: beat driven one edge ago (R7)
    chk("R7", "valid nopipe", 80'(n_v), 80'(e_v[0]));
    chk(e_tag[0], "result nopipe", 80'(n_res), 80'(e_res[0]));
    chk("R9", "ovf nopipe", 80'(n_ovf), 80'(e_ovf[0]));
    chk("R6", "chain nopipe", 80'(n_ch), 80'(e_ch[0]));
    e_v[1] = e_v[0]; e_res[1] = e_res[0]; e_ovf[1] = e_ovf[0];
    e_ch[1] = e_ch[0]; e_tag[1] = e_tag[0];
    in_valid = v; mode = md; acc_clr = clr; a_in = a; b_in = b; chain_in = ch;
    rnd_en = ren; rnd_pos = rp; sat_en = sen; sat_w = sw;
    predict(v, md, clr, a, b, ch, ren, rp, sen, sw);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      beat(1'b0, 2'd1, 1'b0, '0, '0, '0, 1'b0, 7'd0, 1'b0, 7'd0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [95:0] ra, rb;
    logic [63:0] rc;
    int seed;
    seed = int'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 1'b0; mode = 2'd0; acc_clr = 1'b0;
    a_in = '0; b_in = '0; chain_in = '0; rnd_en = 1'b0; rnd_pos = '0;
    sat_en = 1'b0; sat_w = '0;
    macc = '0; last_res = '0;
    for (int i = 0; i < 2; i++) begin
      e_v[i] = 1'b0; e_res[i] = '0; e_ovf[i] = 1'b0; e_ch[i] = '0; e_tag[i] = "R10";
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset valid", 80'(p_v), 80'(0));
    chk("R1", "reset result", 80'(p_res), 80'(0));
    chk("R1", "reset ovf", 80'(p_ovf), 80'(0));
    chk("R1", "reset chain", 80'(p_ch), 80'(0));
    chk("R1", "reset nopipe result", 80'(n_res), 80'(0));
    chk("R1", "reset nopipe valid", 80'(n_v), 80'(0));
    rst = 1'b0;

    // R2 extreme signed operands for the wide multiply
    beat(1'b1, 2'd0, 1'b0, lanes(18'h0, 18'h20000, 18'h15555, 18'h2AAAA),
         lanes(18'h0, 18'h20000, 18'h3FFFF, 18'h1), '0, 1'b0, 7'd0, 1'b0, 7'd0);
    beat(1'b1, 2'd0, 1'b0, lanes(18'h3FFFF, 18'h1FFFF, 18'h0, 18'h0),
         lanes(18'h0, 18'h20000, 18'h0, 18'h0), '0, 1'b0, 7'd0, 1'b0, 7'd0);
    beat(1'b1, 2'd0, 1'b0, lanes(18'h3FFFF, 18'h3FFFF, 18'h0, 18'h0),
         lanes(18'h3FFFF, 18'h3FFFF, 18'h0, 18'h0), '0, 1'b0, 7'd0, 1'b0, 7'd0);
    // R3 most negative operands on all lanes
    beat(1'b1, 2'd1, 1'b0, {4{18'h20000}}, {4{18'h20000}}, '0, 1'b0, 7'd0, 1'b0, 7'd0);
    // R5 chain wraps past the 44-bit limit
    beat(1'b1, 2'd3, 1'b0, lanes(18'd1, 18'd0, 18'd0, 18'd0),
         lanes(18'd1, 18'd0, 18'd0, 18'd0), 44'h7FF_FFFF_FFFF, 1'b0, 7'd0, 1'b0, 7'd0);
    // R4 clear then accumulate, with a gap in between (R10)
    beat(1'b1, 2'd2, 1'b1, lanes(18'd5, 18'd0, 18'd0, 18'd0),
         lanes(18'd1, 18'd0, 18'd0, 18'd0), '0, 1'b0, 7'd0, 1'b0, 7'd0);
    idle(3);
    beat(1'b1, 2'd2, 1'b0, lanes(18'd5, 18'd0, 18'd0, 18'd0),
         lanes(18'd1, 18'd0, 18'd0, 18'd0), '0, 1'b0, 7'd0, 1'b0, 7'd0);
    beat(1'b1, 2'd2, 1'b0, lanes(18'h3FFF9, 18'd0, 18'd0, 18'd0),
         lanes(18'd3, 18'd0, 18'd0, 18'd0), '0, 1'b0, 7'd0, 1'b0, 7'd0);
    // R8 rounding of 6, -6 at k=2 and 3 at k=1
    beat(1'b1, 2'd1, 1'b0, lanes(18'd3, 18'd0, 18'd0, 18'd0),
         lanes(18'd2, 18'd0, 18'd0, 18'd0), '0, 1'b1, 7'd2, 1'b0, 7'd0);
    beat(1'b1, 2'd1, 1'b0, lanes(18'h3FFFD, 18'd0, 18'd0, 18'd0),
         lanes(18'd2, 18'd0, 18'd0, 18'd0), '0, 1'b1, 7'd2, 1'b0, 7'd0);
    beat(1'b1, 2'd1, 1'b0, lanes(18'd3, 18'd0, 18'd0, 18'd0),
         lanes(18'd1, 18'd0, 18'd0, 18'd0), '0, 1'b1, 7'd1, 1'b0, 7'd0);
    // R9 clamp at 16 bits in both directions, and no clamp at the edge
    beat(1'b1, 2'd1, 1'b0, lanes(18'd1000, 18'd0, 18'd0, 18'd0),
         lanes(18'd1000, 18'd0, 18'd0, 18'd0), '0, 1'b0, 7'd0, 1'b1, 7'd16);
    beat(1'b1, 2'd1, 1'b0, lanes(18'h3FC18, 18'd0, 18'd0, 18'd0),
         lanes(18'd1000, 18'd0, 18'd0, 18'd0), '0, 1'b0, 7'd0, 1'b1, 7'd16);
    beat(1'b1, 2'd1, 1'b0, lanes(18'd32767, 18'd0, 18'd0, 18'd0),
         lanes(18'd1, 18'd0, 18'd0, 18'd0), '0, 1'b0, 7'd0, 1'b1, 7'd16);
    idle(2);

    // constrained random stream, all modes mixed
    for (int n = 0; n < 3000; n++) begin
      ra = {$urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom};
      rc = {$urandom, $urandom};
      beat(($urandom % 8) != 0, 2'($urandom % 4), ($urandom % 4) == 0,
           ra[71:0], rb[71:0], rc[43:0],
           ($urandom % 4) == 0, 7'($urandom % 72),
           ($urandom % 4) == 0, 7'(16 + $urandom % 57));
    end
    idle(3);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule